// File: doc/BRIEF.md
# Self-Starting Ten-State Sequence Counter

This block is a synchronous 4-bit counter. Its count order is a fixed, non-binary sequence of ten codes: 0, 2, 3, 5, 8, 7, 15, 12, 11, 10. After 10 it returns to 0. The counter advances one step on each rising clock edge where the enable is high, and it keeps its value when the enable is low. A terminal-count flag marks the last code of the sequence so that a downstream stage can detect the wrap.

Six of the sixteen 4-bit codes are not in the sequence: 1, 4, 6, 9, 13 and 14. A register can still hold one of them after a power-up glitch or an upset. The next-state decoder sends each of these codes to 0, so the counter joins its sequence again on the next enabled edge. The decoder is a case-based lookup over the sequence rather than per-bit excitation equations. All four state bits load together on one edge. The reset is synchronous and active-low.

Top module: `seqcnt_irregular`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `state_q` becomes 0 after that edge and `term_cnt` is low.
- R2: With `cnt_en` high and reset released, each rising edge moves `state_q` one step along 0→2→3→5→8→7→15→12→11→10, with all four bits updated on the same edge.
- R3: From state 10 with `cnt_en` high, the next edge returns `state_q` to 0.
- R4: With `cnt_en` low and reset released, `state_q` keeps its value across the edge.
- R5: `term_cnt` is high exactly when `state_q` equals 10. It is a combinational output and has no added latency.
- R6: The next-state decoder maps each unused code (1, 4, 6, 9, 13, 14) to 0. It maps each of the ten sequence codes to its successor in the order given in R2.
- R7: Reset has priority over enable. A low `rst_n` forces 0 even when `cnt_en` is high.
- R8: Once reset has been released, `state_q` only holds codes from the ten-code sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Advance the sequence on this edge when high |
| state_q | output | 4 | Current counter code |
| term_cnt | output | 1 | High while the state is the last code (10) |

## Verification
Each step, hold and reset result appears on `state_q` one edge after the inputs that caused it. The bench therefore changes its inputs on the falling edge and samples 1 ns after the following rising edge. `term_cnt` is combinational from the state, so it is checked in that same sample. The unused codes cannot be reached through the top-level ports, so the bench drives a separate instance of the decoder with all sixteen codes and checks its combinational output after a short settle delay.

// File: rtl/seqcnt_pkg.sv
// Package: shared widths, the sequence table and the recovery code.
// Assumes the sequence holds no repeated code and fits in CODE_W bits.
package seqcnt_pkg;
    localparam int CODE_W  = 4;
    localparam int SEQ_LEN = 10;
    localparam int IDX_W   = $clog2(SEQ_LEN);

    typedef logic [CODE_W-1:0] code_t;

    // Returns the code at position idx of the count order.
    function automatic code_t seq_code(input int idx);
        case (idx)
            0:       return code_t'(0);
            1:       return code_t'(2);
            2:       return code_t'(3);
            3:       return code_t'(5);
            4:       return code_t'(8);
            5:       return code_t'(7);
            6:       return code_t'(15);
            7:       return code_t'(12);
            8:       return code_t'(11);
            default: return code_t'(10);
        endcase
    endfunction

    localparam code_t START_CODE = seq_code(0);
    localparam code_t TERM_CODE  = seq_code(SEQ_LEN - 1);
    localparam code_t RECOVER_CODE = START_CODE;
endpackage

// File: rtl/seqcnt_next.sv
// Next-state decoder: a purely combinational lookup from the current code
// to its successor. Any code outside the sequence maps to RECOVER_CODE.
// Assumes the package sequence table has no duplicates.
module seqcnt_next
    import seqcnt_pkg::*;
(
    input  logic [CODE_W-1:0] cur_i,
    output logic [CODE_W-1:0] nxt_o
);
    // Case-based successor selection over the sequence positions.
    always_comb begin
        case (cur_i)
            seq_code(0): nxt_o = seq_code(1);
            seq_code(1): nxt_o = seq_code(2);
            seq_code(2): nxt_o = seq_code(3);
            seq_code(3): nxt_o = seq_code(4);
            seq_code(4): nxt_o = seq_code(5);
            seq_code(5): nxt_o = seq_code(6);
            seq_code(6): nxt_o = seq_code(7);
            seq_code(7): nxt_o = seq_code(8);
            seq_code(8): nxt_o = seq_code(9);
            seq_code(9): nxt_o = seq_code(0);
            default:     nxt_o = RECOVER_CODE;
        endcase
    end
endmodule

// File: rtl/seqcnt_reg.sv
// State register: all bits load together on the rising edge.
// Synchronous active-low reset wins over the enable; enable low holds.
module seqcnt_reg
    import seqcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] nxt_i,
    output logic [CODE_W-1:0] q_o
);
    // Update the stored code: reset first, then load or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= START_CODE;
        else if (en_i)
            q_o <= nxt_i;
    end
endmodule

// File: rtl/seqcnt_term.sv
// Terminal detector: flags the last code of the sequence.
// Assumes the flag is wanted combinationally, in the same cycle as the state.
module seqcnt_term
    import seqcnt_pkg::*;
(
    input  logic [CODE_W-1:0] state_i,
    output logic              tc_o
);
    // Compare the current code against the final sequence code.
    always_comb tc_o = (state_i == TERM_CODE);
endmodule

// File: rtl/seqcnt_irregular.sv
// Top: self-starting ten-code counter built from the decoder, the register
// and the terminal detector. Assumes a single clock domain.
module seqcnt_irregular
    import seqcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    output logic [CODE_W-1:0] state_q,
    output logic              term_cnt
);
    logic [CODE_W-1:0] nxt_code;

    seqcnt_next u_next (
        .cur_i (state_q),
        .nxt_o (nxt_code)
    );

    seqcnt_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cnt_en),
        .nxt_i (nxt_code),
        .q_o   (state_q)
    );

    seqcnt_term u_term (
        .state_i (state_q),
        .tc_o    (term_cnt)
    );
endmodule

// File: rtl/seqcnt_irregular_chk.sv
// Checker for seqcnt_irregular: temporal properties over the top ports.
// Attached with the bind below; it drives nothing.
module seqcnt_irregular_chk
    import seqcnt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_en,
    input logic [CODE_W-1:0] state_q,
    input logic              term_cnt
);
    logic in_seq;

    // Independent membership test of the current code.
    always_comb begin
        in_seq = 1'b0;
        for (int i = 0; i < SEQ_LEN; i++)
            if (state_q == seq_code(i)) in_seq = 1'b1;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (state_q == START_CODE) && !term_cnt); // R1

    AST_RESET_OVER_EN: assert property (@(posedge clk)
        (!rst_n && cnt_en) |=> state_q == START_CODE); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(state_q)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && term_cnt) |=> state_q == START_CODE); // R3

    AST_STEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && state_q == seq_code(0)) |=> state_q == seq_code(1)); // R2

    AST_STEP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && state_q == seq_code(6)) |=> state_q == seq_code(7)); // R2

    AST_TC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_cnt) |-> $past(cnt_en) && $past(state_q) == seq_code(SEQ_LEN - 2)); // R5

    AST_VALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) == 1'b0 || $past(rst_n) == 1'b1 |-> in_seq); // R8
endmodule

bind seqcnt_irregular seqcnt_irregular_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .state_q  (state_q),
    .term_cnt (term_cnt)
);

// File: tb/seqcnt_irregular_bench.sv
`timescale 1ns/1ps
module seqcnt_irregular_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [3:0] state_q;
    logic       term_cnt;
    logic [3:0] dec_in = 4'd0;
    logic [3:0] dec_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seqcnt_irregular u_seqcnt_irregular (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .state_q(state_q), .term_cnt(term_cnt)
    );

    seqcnt_next u_dec (.cur_i(dec_in), .nxt_o(dec_out));

    // Each entry: {enable, expected state after the edge}
    localparam logic [4:0] VEC [24] = '{
        {1'b1,4'd2},  {1'b1,4'd3},  {1'b0,4'd3},  {1'b1,4'd5},
        {1'b1,4'd8},  {1'b1,4'd7},  {1'b0,4'd7},  {1'b0,4'd7},
        {1'b1,4'd15}, {1'b1,4'd12}, {1'b1,4'd11}, {1'b1,4'd10},
        {1'b0,4'd10}, {1'b1,4'd0},  {1'b1,4'd2},  {1'b1,4'd3},
        {1'b1,4'd5},  {1'b1,4'd8},  {1'b1,4'd7},  {1'b1,4'd15},
        {1'b1,4'd12}, {1'b1,4'd11}, {1'b1,4'd10}, {1'b1,4'd0}
    };

    // Expected successor, written from the requirement R6.
    function automatic logic [3:0] ref_next(input logic [3:0] c);
        case (c)
            4'd0: return 4'd2;   4'd2: return 4'd3;   4'd3: return 4'd5;
            4'd5: return 4'd8;   4'd8: return 4'd7;   4'd7: return 4'd15;
            4'd15: return 4'd12; 4'd12: return 4'd11; 4'd11: return 4'd10;
            4'd10: return 4'd0;
            default: return 4'd0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive inputs on the falling edge, sample 1 ns after the rising edge.
    task automatic step(input logic rst_v, input logic en_v);
        @(negedge clk);
        rst_n  = rst_v;
        cnt_en = en_v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R1 reset state", state_q, 0);
        check("R1 reset tc", term_cnt, 0);

        // Table walk: sequence order, holds and wrap
        for (int i = 0; i < 24; i++) begin
            step(1'b1, VEC[i][4]);
            if (VEC[i][4] == 1'b0)
                check("R4 hold", state_q, VEC[i][3:0]);
            else if (VEC[i][3:0] == 4'd0)
                check("R3 wrap", state_q, 0);
            else
                check("R2 step", state_q, VEC[i][3:0]);
            check("R5 terminal flag", term_cnt, (VEC[i][3:0] == 4'd10) ? 1 : 0);
        end

        // Reset mid-count with enable high: reset wins
        step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b1);
        check("R2 advance to 8", state_q, 8);
        step(1'b0, 1'b1);
        check("R7 reset over enable", state_q, 0);
        step(1'b0, 1'b0);
        check("R1 reset held", state_q, 0);

        // Run up to 10 and reset there
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1);
        check("R5 tc at 10", term_cnt, 1);
        step(1'b0, 1'b1);
        check("R1 reset from 10", state_q, 0);
        check("R5 tc cleared", term_cnt, 0);

        // Long hold across many edges
        step(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        check("R4 long hold", state_q, 2);

        // Decoder sweep over all 16 codes, unused ones included
        for (int c = 0; c < 16; c++) begin
            dec_in = 4'(c);
            #1;
            check("R6 decoder", dec_out, ref_next(4'(c)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule